// File: doc/BRIEF.md
# Control Character Cursor Action Decoder

This block turns one character from the terminal's data path into cursor register commands (clear column, clear row, up, down, left, right), into page-clear and erase-input requests, and into a terminal-suppress signal that tells the display logic to ignore the character. A character counts only when an execute strobe accepts it. Configuration comes from mode and strap inputs.

The command word is registered at the execute strobe and held until the next step strobe. The cursor counters are outside the block; it reads only the current column. A small escape tracker remembers whether the previous accepted character was ESC, so that FF and SI can be gated behind an escape prefix. Wrap-around turns a move past the last column into a return to the left margin on the next line.

Two state machines make up the block. The hold machine has states HOLD_IDLE and HOLD_BUSY. An execute strobe in HOLD_IDLE loads the commands and moves it to HOLD_BUSY. A step strobe in HOLD_BUSY clears the commands and returns it to HOLD_IDLE. The escape machine has states ESC_CLEAR and ESC_ARMED. Any accepted character sends it to ESC_ARMED if that character is ESC (0x1B) and to ESC_CLEAR otherwise. An accepted home key leaves it unchanged.

Top module: `ctl_cursor_decoder`

## Requirements
- R1: HT (0x09) gives right only, BS (0x08) gives left only, LF (0x0A) gives down, and VT (0x0B) gives up only. Left and right are never asserted together.
- R2: CR (0x0D) gives clear-X, and also down when strap_cr_lf is 1. LF also gives clear-X when strap_lf_cr is 1.
- R3: An execute strobe with home_key high gives clear-X and clear-Y and nothing else, whatever the character.
- R4: FF (0x0C) gives page-clear only if the previous accepted character was ESC or strap_ff_noesc is 1. SI (0x0F) gives erase-input only if the previous accepted character was ESC. ESC itself gives no command.
- R5: After any accepted character other than ESC, the escape prefix is forgotten.
- R6: Rubout (0x7F) asserts term_sup only while dma_active and reset_key are both low, and it moves nothing.
- R7: NUL (0x00) asserts term_sup with no movement. ETX (0x03) asserts term_sup and right.
- R8: While reset_key is high, any control character (0x00 to 0x1F) gives right, plus term_sup for NUL or ETX, and no other command.
- R9: With direct_mode and strap_wrap both 1 and col_x equal to COLS-1 (79), a right move or a printable character (0x20 to 0x7E) gives clear-X plus down instead of right.
- R10: Commands appear in the cycle after the execute strobe and stay unchanged until a step strobe, which clears them. Execute strobes arriving while commands are held are ignored.
- R11: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_stb | input | 1 | Execute strobe; accepts the character and the home key |
| step_stb | input | 1 | Step strobe; releases the held commands |
| char_vld | input | 1 | A character accompanies the execute strobe |
| char_in | input | 7 | Character code |
| home_key | input | 1 | Home key pressed |
| reset_key | input | 1 | Reset key held |
| dma_active | input | 1 | Memory scan in progress |
| direct_mode | input | 1 | Keyboard goes directly to the host |
| strap_cr_lf | input | 1 | CR also moves down |
| strap_lf_cr | input | 1 | LF also clears the column |
| strap_ff_noesc | input | 1 | FF acts without an escape prefix |
| strap_wrap | input | 1 | Wrap-around enable |
| col_x | input | 7 | Current cursor column |
| cmd_clrx | output | 1 | Clear column counter |
| cmd_clry | output | 1 | Clear row counter |
| cmd_up | output | 1 | Move up one row |
| cmd_down | output | 1 | Move down one row |
| cmd_left | output | 1 | Move left one column |
| cmd_right | output | 1 | Move right one column |
| term_sup | output | 1 | Terminal ignores this character |
| page_clear | output | 1 | Start page clear |
| erase_input | output | 1 | Start erase input |

## Verification
The checker watches every cycle for these properties: held commands stay stable until a step strobe, which clears them; left and right are never asserted together; the home key yields both clears; a rubout during DMA is never suppressed; and a wrap position never yields right. The decode table, both line-coupling straps, the escape prefix and how it is forgotten, the effect of the reset key, and rubout suppression outside DMA need the bench's scripted character sequences, because the expected result depends on the characters that came before.

// File: rtl/ctl_cursor_pkg.sv
package ctl_cursor_pkg;

    localparam int unsigned CHAR_W = 7;

    localparam logic [CHAR_W-1:0] CH_NUL = 7'h00;
    localparam logic [CHAR_W-1:0] CH_ETX = 7'h03;
    localparam logic [CHAR_W-1:0] CH_BS  = 7'h08;
    localparam logic [CHAR_W-1:0] CH_HT  = 7'h09;
    localparam logic [CHAR_W-1:0] CH_LF  = 7'h0A;
    localparam logic [CHAR_W-1:0] CH_VT  = 7'h0B;
    localparam logic [CHAR_W-1:0] CH_FF  = 7'h0C;
    localparam logic [CHAR_W-1:0] CH_CR  = 7'h0D;
    localparam logic [CHAR_W-1:0] CH_SI  = 7'h0F;
    localparam logic [CHAR_W-1:0] CH_ESC = 7'h1B;
    localparam logic [CHAR_W-1:0] CH_SP  = 7'h20;
    localparam logic [CHAR_W-1:0] CH_DEL = 7'h7F;

    typedef struct packed {
        logic clrx;
        logic clry;
        logic up;
        logic down;
        logic left;
        logic right;
        logic tsup;
        logic pclr;
        logic erin;
    } cur_cmd_t;

    typedef enum logic { HOLD_IDLE, HOLD_BUSY } hold_state_t;
    typedef enum logic { ESC_CLEAR, ESC_ARMED } esc_state_t;

endpackage

// File: rtl/ctl_cursor_decode.sv
module ctl_cursor_decode
    import ctl_cursor_pkg::*;
#(
    parameter int unsigned COLS  = 80,
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic [CHAR_W-1:0] char_in,
    input  logic              char_vld,
    input  logic              home_key,
    input  logic              reset_key,
    input  logic              dma_active,
    input  logic              direct_mode,
    input  logic              strap_cr_lf,
    input  logic              strap_lf_cr,
    input  logic              strap_ff_noesc,
    input  logic              strap_wrap,
    input  logic              esc_armed,
    input  logic [COL_W-1:0]  col_x,
    output cur_cmd_t          cmd
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic     is_ctrl;
    logic     is_print;
    logic     at_wrap;
    cur_cmd_t base;

    assign is_ctrl  = (char_in < CH_SP);
    assign is_print = !is_ctrl && (char_in != CH_DEL);
    assign at_wrap  = direct_mode && strap_wrap && (col_x == LAST_COL);

    always_comb begin
        base = '0;
        if (reset_key && is_ctrl) begin
            base.right = 1'b1;
            base.tsup  = (char_in == CH_NUL) || (char_in == CH_ETX);
        end else begin
            unique case (char_in)
                CH_HT:  base.right = 1'b1;
                CH_BS:  base.left  = 1'b1;
                CH_VT:  base.up    = 1'b1;
                CH_LF: begin
                    base.down = 1'b1;
                    base.clrx = strap_lf_cr;
                end
                CH_CR: begin
                    base.clrx = 1'b1;
                    base.down = strap_cr_lf;
                end
                CH_ETX: begin
                    base.tsup  = 1'b1;
                    base.right = 1'b1;
                end
                CH_NUL: base.tsup = 1'b1;
                CH_FF:  base.pclr = esc_armed || strap_ff_noesc;
                CH_SI:  base.erin = esc_armed;
                CH_DEL: base.tsup = !dma_active && !reset_key;
                default: base = '0;
            endcase
        end
    end

    always_comb begin
        cmd = '0;
        if (home_key) begin
            cmd.clrx = 1'b1;
            cmd.clry = 1'b1;
        end else if (char_vld) begin
            cmd = base;
            if (at_wrap && (base.right || is_print)) begin
                cmd.right = 1'b0;
                cmd.clrx  = 1'b1;
                cmd.down  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ctl_cursor_esc.sv
module ctl_cursor_esc
    import ctl_cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              char_vld,
    input  logic              home_key,
    input  logic [CHAR_W-1:0] char_in,
    output logic              esc_armed
);

    esc_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ESC_CLEAR;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (accept && char_vld && !home_key) begin
            unique case (st_q)
                ESC_CLEAR: st_d = (char_in == CH_ESC) ? ESC_ARMED : ESC_CLEAR;
                ESC_ARMED: st_d = (char_in == CH_ESC) ? ESC_ARMED : ESC_CLEAR;
                default:   st_d = ESC_CLEAR;
            endcase
        end
    end

    assign esc_armed = (st_q == ESC_ARMED);

endmodule

// File: rtl/ctl_cursor_hold.sv
module ctl_cursor_hold
    import ctl_cursor_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     exec_stb,
    input  logic     step_stb,
    input  cur_cmd_t cmd_in,
    output logic     accept,
    output logic     busy,
    output cur_cmd_t cmd_q
);

    hold_state_t st_q, st_d;

    assign accept = (st_q == HOLD_IDLE) && exec_stb;
    assign busy   = (st_q == HOLD_BUSY);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HOLD_IDLE: if (exec_stb) st_d = HOLD_BUSY;
            HOLD_BUSY: if (step_stb) st_d = HOLD_IDLE;
            default:   st_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= HOLD_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           cmd_q <= '0;
        else if (accept)                      cmd_q <= cmd_in;
        else if (st_q == HOLD_BUSY && step_stb) cmd_q <= '0;
    end

endmodule

// File: rtl/ctl_cursor_decoder.sv
module ctl_cursor_decoder
    import ctl_cursor_pkg::*;
#(
    parameter int unsigned COLS  = 80,
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_stb,
    input  logic              step_stb,
    input  logic              char_vld,
    input  logic [CHAR_W-1:0] char_in,
    input  logic              home_key,
    input  logic              reset_key,
    input  logic              dma_active,
    input  logic              direct_mode,
    input  logic              strap_cr_lf,
    input  logic              strap_lf_cr,
    input  logic              strap_ff_noesc,
    input  logic              strap_wrap,
    input  logic [COL_W-1:0]  col_x,
    output logic              cmd_clrx,
    output logic              cmd_clry,
    output logic              cmd_up,
    output logic              cmd_down,
    output logic              cmd_left,
    output logic              cmd_right,
    output logic              term_sup,
    output logic              page_clear,
    output logic              erase_input
);

    cur_cmd_t next_cmd;
    cur_cmd_t held_cmd;
    logic     accept;
    logic     hold_busy;
    logic     esc_armed;

    ctl_cursor_decode #(.COLS(COLS), .COL_W(COL_W)) u_decode (
        .char_in        (char_in),
        .char_vld       (char_vld),
        .home_key       (home_key),
        .reset_key      (reset_key),
        .dma_active     (dma_active),
        .direct_mode    (direct_mode),
        .strap_cr_lf    (strap_cr_lf),
        .strap_lf_cr    (strap_lf_cr),
        .strap_ff_noesc (strap_ff_noesc),
        .strap_wrap     (strap_wrap),
        .esc_armed      (esc_armed),
        .col_x          (col_x),
        .cmd            (next_cmd)
    );

    ctl_cursor_esc u_esc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .char_vld  (char_vld),
        .home_key  (home_key),
        .char_in   (char_in),
        .esc_armed (esc_armed)
    );

    ctl_cursor_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec_stb (exec_stb),
        .step_stb (step_stb),
        .cmd_in   (next_cmd),
        .accept   (accept),
        .busy     (hold_busy),
        .cmd_q    (held_cmd)
    );

    assign cmd_clrx    = held_cmd.clrx;
    assign cmd_clry    = held_cmd.clry;
    assign cmd_up      = held_cmd.up;
    assign cmd_down    = held_cmd.down;
    assign cmd_left    = held_cmd.left;
    assign cmd_right   = held_cmd.right;
    assign term_sup    = held_cmd.tsup;
    assign page_clear  = held_cmd.pclr;
    assign erase_input = held_cmd.erin;

endmodule

// File: rtl/ctl_cursor_decoder_chk.sv
module ctl_cursor_decoder_chk #(
    parameter int unsigned COLS  = 80,
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exec_stb,
    input logic             step_stb,
    input logic             char_vld,
    input logic [6:0]       char_in,
    input logic             home_key,
    input logic             dma_active,
    input logic             direct_mode,
    input logic             strap_wrap,
    input logic [COL_W-1:0] col_x,
    input logic             holding,
    input logic [8:0]       outs
);

    logic take;
    logic wrap_pos;
    assign take     = !holding && exec_stb;
    assign wrap_pos = direct_mode && strap_wrap && (col_x == COL_W'(COLS - 1));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && !step_stb) |=> $stable(outs));

    assert_step_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (holding && step_stb) |=> (outs == 9'd0));

    assert_no_left_right_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(outs[4] && outs[3]));

    assert_home_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && home_key) |=> (outs[8] && outs[7]));

    assert_dma_rubout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && char_vld && !home_key && char_in == 7'h7F && dma_active) |=> !outs[2]);

    assert_wrap_no_right_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && char_vld && !home_key && wrap_pos) |=> !outs[3]);

endmodule

bind ctl_cursor_decoder ctl_cursor_decoder_chk #(.COLS(COLS), .COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exec_stb    (exec_stb),
    .step_stb    (step_stb),
    .char_vld    (char_vld),
    .char_in     (char_in),
    .home_key    (home_key),
    .dma_active  (dma_active),
    .direct_mode (direct_mode),
    .strap_wrap  (strap_wrap),
    .col_x       (col_x),
    .holding     (hold_busy),
    .outs        ({cmd_clrx, cmd_clry, cmd_up, cmd_down, cmd_left, cmd_right,
                   term_sup, page_clear, erase_input})
);

// File: tb/ctl_cursor_decoder_bench.sv
module ctl_cursor_decoder_bench;

    // expected word order: clrx clry up down left right tsup pclr erin
    localparam logic [8:0] X_CLRX = 9'b100000000;
    localparam logic [8:0] X_CLRY = 9'b010000000;
    localparam logic [8:0] X_UP   = 9'b001000000;
    localparam logic [8:0] X_DOWN = 9'b000100000;
    localparam logic [8:0] X_LEFT = 9'b000010000;
    localparam logic [8:0] X_RGHT = 9'b000001000;
    localparam logic [8:0] X_TSUP = 9'b000000100;
    localparam logic [8:0] X_PCLR = 9'b000000010;
    localparam logic [8:0] X_ERIN = 9'b000000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic exec_stb = 1'b0, step_stb = 1'b0, char_vld = 1'b0;
    logic [6:0] char_in = '0;
    logic home_key = 1'b0, reset_key = 1'b0, dma_active = 1'b0, direct_mode = 1'b0;
    logic strap_cr_lf = 1'b1, strap_lf_cr = 1'b0, strap_ff_noesc = 1'b0, strap_wrap = 1'b0;
    logic [6:0] col_x = '0;
    logic o_clrx, o_clry, o_up, o_down, o_left, o_right, o_tsup, o_pclr, o_erin;
    logic [8:0] obs;

    int n_checks = 0;
    int n_fails  = 0;

    typedef struct {
        logic [8:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];
    event     mon_ev;

    always #2 clk = ~clk;

    assign obs = {o_clrx, o_clry, o_up, o_down, o_left, o_right, o_tsup, o_pclr, o_erin};

    ctl_cursor_decoder u_ctl_cursor_decoder (
        .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .step_stb(step_stb),
        .char_vld(char_vld), .char_in(char_in), .home_key(home_key),
        .reset_key(reset_key), .dma_active(dma_active), .direct_mode(direct_mode),
        .strap_cr_lf(strap_cr_lf), .strap_lf_cr(strap_lf_cr),
        .strap_ff_noesc(strap_ff_noesc), .strap_wrap(strap_wrap), .col_x(col_x),
        .cmd_clrx(o_clrx), .cmd_clry(o_clry), .cmd_up(o_up), .cmd_down(o_down),
        .cmd_left(o_left), .cmd_right(o_right), .term_sup(o_tsup),
        .page_clear(o_pclr), .erase_input(o_erin)
    );

    // monitor: pops one expected item per event and compares
    always @(mon_ev) begin
        sb_item_t it;
        if (sb_q.size() == 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL %s: scoreboard empty, actual %b expected none", "R10", obs);
        end else begin
            it = sb_q.pop_front();
            n_checks++;
            if (obs !== it.exp) begin
                n_fails++;
                $display("FAIL %s: actual %b expected %b", it.tag, obs, it.exp);
            end
        end
    end

    task automatic expect_now(input logic [8:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        -> mon_ev;
        #0;
    endtask

    task automatic release_step();
        @(negedge clk) step_stb = 1'b1;
        @(negedge clk) step_stb = 1'b0;
    endtask

    // drive one character through execute, check, then release with step
    task automatic send(input logic [6:0] ch, input logic [8:0] exp, input string tag);
        @(negedge clk);
        char_in  = ch;
        char_vld = 1'b1;
        exec_stb = 1'b1;
        @(negedge clk);
        exec_stb = 1'b0;
        char_vld = 1'b0;
        expect_now(exp, tag);
        release_step();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_now(9'd0, "R11 reset");

        send(7'h09, X_RGHT, "R1 HT");
        send(7'h08, X_LEFT, "R1 BS");
        send(7'h0A, X_DOWN, "R1 LF");
        send(7'h0B, X_UP,   "R1 VT");

        send(7'h0D, X_CLRX | X_DOWN, "R2 CR with cr_lf");
        strap_cr_lf = 1'b0;
        send(7'h0D, X_CLRX, "R2 CR without cr_lf");
        strap_lf_cr = 1'b1;
        send(7'h0A, X_CLRX | X_DOWN, "R2 LF with lf_cr");
        strap_lf_cr = 1'b0;
        strap_cr_lf = 1'b1;

        home_key = 1'b1;
        send(7'h41, X_CLRX | X_CLRY, "R3 home");
        home_key = 1'b0;

        send(7'h0C, 9'd0,   "R4 FF without ESC");
        send(7'h1B, 9'd0,   "R4 ESC alone");
        send(7'h0C, X_PCLR, "R4 ESC FF");
        send(7'h1B, 9'd0,   "R4 ESC alone");
        send(7'h0F, X_ERIN, "R4 ESC SI");
        send(7'h0F, 9'd0,   "R4 SI without ESC");
        strap_ff_noesc = 1'b1;
        send(7'h0C, X_PCLR, "R4 FF strap");
        strap_ff_noesc = 1'b0;

        send(7'h1B, 9'd0, "R5 ESC");
        send(7'h41, 9'd0, "R5 printable");
        send(7'h0C, 9'd0, "R5 FF after cleared prefix");
        send(7'h1B, 9'd0, "R5 ESC");
        send(7'h0A, X_DOWN, "R5 LF");
        send(7'h0F, 9'd0, "R5 SI after cleared prefix");

        send(7'h7F, X_TSUP, "R6 rubout");
        dma_active = 1'b1;
        send(7'h7F, 9'd0, "R6 rubout during DMA");
        dma_active = 1'b0;
        reset_key = 1'b1;
        send(7'h7F, 9'd0, "R6 rubout with reset key");

        send(7'h08, X_RGHT, "R8 BS with reset key");
        send(7'h0D, X_RGHT, "R8 CR with reset key");
        send(7'h00, X_RGHT | X_TSUP, "R8 NUL with reset key");
        reset_key = 1'b0;

        send(7'h00, X_TSUP, "R7 NUL");
        send(7'h03, X_TSUP | X_RGHT, "R7 ETX");

        col_x = 7'd79;
        send(7'h09, X_RGHT, "R9 HT col 79 no wrap mode");
        direct_mode = 1'b1;
        strap_wrap  = 1'b1;
        send(7'h09, X_CLRX | X_DOWN, "R9 HT wrap");
        send(7'h41, X_CLRX | X_DOWN, "R9 printable wrap");
        col_x = 7'd78;
        send(7'h09, X_RGHT, "R9 HT col 78");
        send(7'h41, 9'd0,   "R9 printable col 78");
        direct_mode = 1'b0;
        strap_wrap  = 1'b0;
        col_x = 7'd0;

        // R10: hold across cycles, ignore execute while held, clear on step
        @(negedge clk);
        char_in = 7'h09; char_vld = 1'b1; exec_stb = 1'b1;
        @(negedge clk);
        expect_now(X_RGHT, "R10 loaded");
        char_in = 7'h08;
        @(negedge clk);
        exec_stb = 1'b0; char_vld = 1'b0;
        repeat (2) @(negedge clk);
        expect_now(X_RGHT, "R10 held, second execute ignored");
        release_step();
        expect_now(9'd0, "R10 cleared by step");
        @(negedge clk);
        expect_now(9'd0, "R10 stays clear");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule